// File: doc/BRIEF.md
# Seconds Timekeeper with Alarm

This block keeps time in whole seconds from a 32 kHz reference clock. A prescaler divides the reference down to a one-second pulse that is high for exactly one reference cycle. A seconds counter advances on the reference edge that ends that pulse. In effect, the count steps on the pulse's falling edge. Software can load the counter with any value at any time.

An alarm register is compared with the counter. When the counter takes the alarm value, a sticky status bit is set. This happens whether the counter reached the value by counting up or by being written. Two enable bits route the status bit to an interrupt output and to a wake output. The status bit is cleared by writing one to it.

The register port is a plain single-cycle bus. Reads are combinational and writes take effect on the next clock edge. There are two reset inputs, one from the hardware reset and one from the watchdog, and each clears all state. A low-power indication input can be read back through the status register and has no effect on timekeeping.

Top module: `rtc_timekeeper`

## Requirements
- R1: While either `hw_rst` or `wdt_rst` is high at a clock edge, that edge clears the counter, the alarm, the status bit, both enable bits and the prescaler. As a result, every register reads zero afterwards (apart from status bit 1, which mirrors `low_power`).
- R2: `tick_1hz` is high for exactly one clock cycle in every `PRESCALE` cycles. It first rises `PRESCALE` edges after reset is released.
- R3: The counter, read at address 0, increments by one at the clock edge that ends a cycle in which `tick_1hz` is high, and holds its value at every other edge.
- R4: A write to address 0 loads the written value at the next edge. If that edge also ends a tick cycle, the write takes priority and the tick is dropped.
- R5: The alarm is written and read at address 1. Status bit 0 (address 2) is set at the edge where the counter takes the alarm value, whether by an increment or by a write.
- R6: Status bit 0 stays set until a write to address 2 with data bit 0 equal to one. A write with data bit 0 equal to zero leaves it unchanged. It is not set again while the counter merely holds the alarm value.
- R7: When a clearing write to status and an alarm match land on the same edge, status bit 0 ends up set.
- R8: Address 3 holds the enables: bit 0 is the interrupt enable and bit 1 is the wake enable. `irq` equals status bit 0 AND bit 0 of address 3. `wake` equals status bit 0 AND bit 1 of address 3.
- R9: The counter wraps from 32'hFFFFFFFF to zero. The wrap sets no status bit unless the alarm equals zero.
- R10: `low_power` does not alter counting, ticking or the alarm. Status bit 1 reads its present value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32 kHz reference clock |
| hw_rst | input | 1 | Synchronous active-high hardware reset |
| wdt_rst | input | 1 | Synchronous active-high watchdog reset |
| low_power | input | 1 | Sleep or idle indication, read back only |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 counter, 1 alarm, 2 status, 3 enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| tick_1hz | output | 1 | One-cycle-wide seconds pulse |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wake-up request |

## Verification
Two pairs of events can fall on the same edge. The first is a software load of the counter and a prescaler tick. The second is an alarm match and a write-one-to-clear of the status bit. The bench provokes each collision by waiting until its own model shows the tick pulse high, then driving the write in that same cycle. It judges the result by reading back the loaded count, which must equal the written value with no extra increment, and a status bit that must still be set. A cycle-accurate reference model is compared against every output on every cycle around these edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CNT_W = 32;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_ALARM  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wake_en;
        logic irq_en;
    } enable_t;

    typedef struct packed {
        logic             load;
        logic             step;
        logic [CNT_W-1:0] value;
    } cnt_req_t;

    function automatic logic [CNT_W-1:0] next_count(
        input logic [CNT_W-1:0] cur,
        input cnt_req_t         req
    );
        if (req.load)
            return req.value;
        else if (req.step)
            return cur + CNT_W'(1);
        else
            return cur;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int DW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [DW-1:0] LAST = DW'(PRESCALE - 1);

    logic [DW-1:0] div_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (div_q == LAST);
            div_q   <= (div_q == LAST) ? '0 : div_q + DW'(1);
        end
    end

    assign tick_o = pulse_q;

endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);
    cnt_req_t         req;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        req.load  = load;
        req.step  = tick;
        req.value = load_val;
        cnt_d     = next_count(cnt_q, req);
        match_o   = (load || tick) && (cnt_d == alarm);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             match,
    input  logic             low_power,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] alarm_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] rdata,
    output logic             irq,
    output logic             wake
);
    logic [CNT_W-1:0] alarm_q;
    logic             flag_q;
    enable_t          en_q;
    logic             clr_req;

    assign clr_req = we && (sel == SEL_STATUS) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            flag_q  <= 1'b0;
            en_q    <= '0;
        end else begin
            if (we && sel == SEL_ALARM)
                alarm_q <= wdata;
            if (we && sel == SEL_ENABLE)
                en_q <= enable_t'(wdata[1:0]);
            if (match)
                flag_q <= 1'b1;
            else if (clr_req)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_COUNT:  rdata = count;
            SEL_ALARM:  rdata = alarm_q;
            SEL_STATUS: rdata = {{(CNT_W-2){1'b0}}, low_power, flag_q};
            SEL_ENABLE: rdata = {{(CNT_W-2){1'b0}}, en_q};
            default:    rdata = '0;
        endcase
    end

    assign alarm_o = alarm_q;
    assign flag_o  = flag_q;
    assign irq     = flag_q && en_q.irq_en;
    assign wake    = flag_q && en_q.wake_en;

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic             clk,
    input  logic             hw_rst,
    input  logic             wdt_rst,
    input  logic             low_power,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             tick_1hz,
    output logic             irq,
    output logic             wake
);
    logic             rst;
    logic             pulse;
    logic             cnt_load;
    logic             alarm_hit;
    logic             alarm_flag;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] alarm_val;
    reg_sel_e         sel;

    assign rst      = hw_rst || wdt_rst;
    assign sel      = reg_sel_e'(bus_addr);
    assign cnt_load = bus_we && (sel == SEL_COUNT);

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (pulse)
    );

    rtc_seconds u_sec (
        .clk      (clk),
        .rst      (rst),
        .tick     (pulse),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .alarm    (alarm_val),
        .count_o  (cnt_q),
        .match_o  (alarm_hit)
    );

    rtc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .sel       (sel),
        .wdata     (bus_wdata),
        .match     (alarm_hit),
        .low_power (low_power),
        .count     (cnt_q),
        .alarm_o   (alarm_val),
        .flag_o    (alarm_flag),
        .rdata     (bus_rdata),
        .irq       (irq),
        .wake      (wake)
    );

    assign tick_1hz = pulse;

endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk (
    input logic        clk,
    input logic        hw_rst,
    input logic        wdt_rst,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        tick_1hz,
    input logic        irq,
    input logic        wake,
    input logic [31:0] cnt,
    input logic        flag
);
    logic ld;
    logic clr;
    assign ld  = bus_we && (bus_addr == 2'd0);
    assign clr = bus_we && (bus_addr == 2'd2) && bus_wdata[0];

    // R2
    tick_one_cycle_chk: assert property (@(posedge clk) disable iff (hw_rst || wdt_rst)
        tick_1hz |=> !tick_1hz);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (hw_rst || wdt_rst)
        (tick_1hz && !ld) |=> (cnt == 32'($past(cnt) + 32'd1)));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (hw_rst || wdt_rst)
        (!tick_1hz && !ld) |=> $stable(cnt));

    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (hw_rst || wdt_rst)
        ld |=> (cnt == $past(bus_wdata)));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (hw_rst || wdt_rst)
        (flag && !clr) |=> flag);

    // R8
    out_gate_chk: assert property (@(posedge clk) disable iff (hw_rst || wdt_rst)
        (irq || wake) |-> flag);

    // R1
    wdt_clear_chk: assert property (@(posedge clk) disable iff (hw_rst)
        wdt_rst |=> (cnt == 32'd0 && !flag));

endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
    .clk       (clk),
    .hw_rst    (hw_rst),
    .wdt_rst   (wdt_rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick_1hz  (tick_1hz),
    .irq       (irq),
    .wake      (wake),
    .cnt       (cnt_q),
    .flag      (alarm_flag)
);

// File: tb/tb_rtc_timekeeper.sv
module tb_rtc_timekeeper;
    localparam int CLK_PERIOD = 10;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        hw_rst = 1'b1;
    logic        wdt_rst = 1'b0;
    logic        low_power = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1hz, irq, wake;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int          m_div = 0;
    bit          m_hz = 0, m_flag = 0, m_ie = 0, m_we = 0;
    logic [31:0] m_cnt = '0, m_alarm = '0;

    rtc_timekeeper #(.PRESCALE(P)) dut (
        .clk(clk), .hw_rst(hw_rst), .wdt_rst(wdt_rst), .low_power(low_power),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_1hz(tick_1hz), .irq(irq), .wake(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (hw_rst || wdt_rst) begin
            m_div = 0; m_hz = 0; m_flag = 0; m_ie = 0; m_we = 0;
            m_cnt = '0; m_alarm = '0;
        end else begin
            bit          ld, hit, nhz;
            logic [31:0] nxt;
            ld  = bus_we && bus_addr == 2'd0;
            nxt = ld ? bus_wdata : (m_hz ? m_cnt + 32'd1 : m_cnt);
            hit = (ld || m_hz) && nxt == m_alarm;
            nhz = (m_div == P - 1);
            m_div = nhz ? 0 : m_div + 1;
            if (hit) m_flag = 1;
            else if (bus_we && bus_addr == 2'd2 && bus_wdata[0]) m_flag = 0;
            if (bus_we && bus_addr == 2'd1) m_alarm = bus_wdata;
            if (bus_we && bus_addr == 2'd3) begin m_ie = bus_wdata[0]; m_we = bus_wdata[1]; end
            m_cnt = nxt;
            m_hz  = nhz;
        end
    end

    function automatic logic [31:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_alarm;
            2'd2: return {30'd0, low_power, m_flag};
            default: return {30'd0, m_we, m_ie};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 tick", {31'd0, tick_1hz}, {31'd0, m_hz});
        chk("R8 irq",  {31'd0, irq},  {31'd0, m_flag & m_ie});
        chk("R8 wake", {31'd0, wake}, {31'd0, m_flag & m_we});
        chk("R3 rdata", bus_rdata, model_rd(bus_addr));
    endtask

    task automatic cyc(input bit we, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        check_all();
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0);
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        check_all();
        bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr_on_tick(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        check_all();
        bus_we = 1'b0; bus_addr = 2'd0;
        while (!m_hz) begin
            @(negedge clk);
            check_all();
        end
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        expect_rd(2'd0, 32'd0, "R1 count after hw reset");
        expect_rd(2'd2, 32'd0, "R1 status after hw reset");
        hw_rst = 1'b0;
        idle(3 * P + 2);

        // R4: load collides with tick, write wins
        wr_on_tick(2'd0, 32'd100);
        expect_rd(2'd0, 32'd100, "R4 load over tick");
        idle(8);
        expect_rd(2'd0, 32'd101, "R3 step after tick");

        // R5/R8: alarm by counting, interrupt enabled only
        cyc(1'b1, 2'd3, 32'd1);
        cyc(1'b1, 2'd1, 32'd103);
        expect_rd(2'd1, 32'd103, "R5 alarm readback");
        idle(3 * P);
        expect_rd(2'd2, 32'd1, "R5 flag on count match");
        chk("R8 irq enabled", {31'd0, irq}, 32'd1);
        chk("R8 wake disabled", {31'd0, wake}, 32'd0);

        // R6: zero write ignored, one write clears, no re-set while holding
        cyc(1'b1, 2'd2, 32'd0);
        expect_rd(2'd2, 32'd1, "R6 zero write keeps flag");
        cyc(1'b1, 2'd2, 32'd1);
        expect_rd(2'd2, 32'd0, "R6 clear by one");
        idle(2 * P);
        expect_rd(2'd2, 32'd0, "R6 stays clear");

        // R7: match and clear on the same edge
        wr_on_tick(2'd0, 32'd200);
        cyc(1'b1, 2'd1, 32'd201);
        wr_on_tick(2'd2, 32'd1);
        expect_rd(2'd2, 32'd1, "R7 set beats clear");
        cyc(1'b1, 2'd2, 32'd1);

        // R5: match by counter write, wake path
        cyc(1'b1, 2'd3, 32'd2);
        cyc(1'b1, 2'd1, 32'd500);
        cyc(1'b1, 2'd0, 32'd500);
        expect_rd(2'd2, 32'd1, "R5 flag on write match");
        chk("R8 wake enabled", {31'd0, wake}, 32'd1);
        chk("R8 irq disabled", {31'd0, irq}, 32'd0);
        cyc(1'b1, 2'd2, 32'd1);

        // R9: wrap without flag
        cyc(1'b1, 2'd1, 32'd5);
        wr_on_tick(2'd0, 32'hFFFF_FFFF);
        idle(10);
        expect_rd(2'd0, 32'd0, "R9 wrap to zero");
        expect_rd(2'd2, 32'd0, "R9 no flag on wrap");

        // R10: low-power indication has no effect
        low_power = 1'b1;
        expect_rd(2'd2, 32'd2, "R10 status mirrors low_power");
        wr_on_tick(2'd0, 32'd50);
        idle(9);
        expect_rd(2'd0, 32'd51, "R10 counting in low power");
        low_power = 1'b0;

        // R1: watchdog reset
        wdt_rst = 1'b1;
        idle(2);
        wdt_rst = 1'b0;
        expect_rd(2'd0, 32'd0, "R1 count after watchdog");
        expect_rd(2'd3, 32'd0, "R1 enables after watchdog");
        expect_rd(2'd1, 32'd0, "R1 alarm after watchdog");
        idle(P + 2);
        finish_run();
    end

endmodule